// File: doc/BRIEF.md
# Dataflow Operand Pairing Store

This block sits at the input of a tagged-token dataflow processing element and pairs the two operands of every two-input instruction. Each incoming token names a context slot (4 bits), an instruction offset (7 bits), a side (left or right) and a 16-bit value. For offsets in the two-input range, the block looks up a cell selected jointly by context and offset. If the opposite side is still missing, it parks the token there. If the opposite side is already parked, it issues a fire packet that carries both values and frees the cell. Offsets in the single-input range never touch storage and produce a fire packet straight away.

Waiting in a cell is the only throttling the machine has. A token whose partner never comes stays parked for good, which is how a permit-gated instruction stalls until its permit arrives. The output is a one-entry registered fire packet with valid/ready flow control, and the token input follows the readiness of the downstream consumer.

Top module: `operand_pair_unit`

## Requirements
- R1: After reset `fire_valid_o` and `collide_o` are 0, and every cell is empty, so the first token sent to any two-input cell does not fire.
- R2: A token accepted with offset 32 or above produces a fire packet one cycle later with `fire_mono_o`=1, the token's context and offset, its value on `fire_lval_o` and 0 on `fire_rval_o`, whatever its side.
- R3: A single-input token never reads or writes a cell: a value parked at (ctx, off) with off below 32 is unchanged by single-input tokens whose low five offset bits equal off.
- R4: An accepted two-input token (offset 0..31) whose opposite side is empty is parked and produces no fire packet.
- R5: An accepted two-input token whose opposite side is parked produces, one cycle later, a fire packet with `fire_mono_o`=0, the left value (side code 0) on `fire_lval_o` and the right value (side code 1) on `fire_rval_o`.
- R6: Firing clears both sides of the cell in the same cycle, so the next token sent to that cell is parked again.
- R7: Cells are selected by the pair (context, offset): the same offset under different contexts pairs independently.
- R8: A token for a side that is already parked in its cell sets `collide_o`, which stays 1 until reset. The token is dropped, no packet fires, and the parked value is kept.
- R9: `tok_ready_o` follows `fire_ready_i`. While `fire_ready_i` is 0, no token is accepted and a pending fire packet holds its valid and its contents unchanged.
- R10: A parked token waits with no time limit: a partner that arrives hundreds of cycles later still fires with the parked value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid_i | input | 1 | Incoming token is valid |
| tok_ready_o | output | 1 | Block can take a token this cycle |
| tok_ctx_i | input | 4 | Context slot of the token |
| tok_off_i | input | 7 | Instruction offset of the token |
| tok_port_i | input | 1 | Side of the token: 0 left, 1 right |
| tok_data_i | input | 16 | Token value |
| fire_valid_o | output | 1 | Fire packet is valid |
| fire_ready_i | input | 1 | Consumer takes the fire packet |
| fire_ctx_o | output | 4 | Context of the firing instruction |
| fire_off_o | output | 7 | Offset of the firing instruction |
| fire_lval_o | output | 16 | Left operand (or the single operand) |
| fire_rval_o | output | 16 | Right operand, 0 for single-input fires |
| fire_mono_o | output | 1 | Packet came from the single-input bypass |
| collide_o | output | 1 | Sticky flag: a token hit an already parked side |

## Verification
The output register can be drained by the consumer in the same cycle that a newly accepted token loads it again. This happens when a pairing token or a single-input token follows a fire without an idle cycle, and the bench provokes it by streaming back-to-back tokens while `fire_ready_i` stays high over random stretches. A second overlap occurs when a cell is cleared by a fire and a token for that same cell arrives in the very next cycle. The random stream uses only a few offsets, so this reuse happens often. Both cases are judged against a bench model that advances its expected packet and cell state once per clock edge and compares every field one time unit after the edge.

// File: rtl/opm_pkg.sv
package opm_pkg;
    localparam int CTX_W      = 4;
    localparam int OFF_W      = 7;
    localparam int DATA_W     = 16;
    localparam int DYAD_LIMIT = 32;
    localparam int DYAD_IDX_W = $clog2(DYAD_LIMIT);
    localparam int CELL_IDX_W = CTX_W + DYAD_IDX_W;
    localparam int CELLS      = 1 << CELL_IDX_W;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    typedef struct packed {
        logic [CTX_W-1:0]  ctx;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] lval;
        logic [DATA_W-1:0] rval;
        logic              mono;
    } fire_t;
endpackage

// File: rtl/opm_decode.sv
module opm_decode
    import opm_pkg::*;
(
    input  logic [CTX_W-1:0]      ctx_i,
    input  logic [OFF_W-1:0]      off_i,
    output logic                  dyad_o,
    output logic [CELL_IDX_W-1:0] idx_o
);
    localparam bit LIMIT_POW2 = (DYAD_LIMIT == (1 << DYAD_IDX_W));

    generate
        if (LIMIT_POW2) begin : g_pow2
            // limit is a power of two: only the upper offset bits matter
            assign dyad_o = ~|off_i[OFF_W-1:DYAD_IDX_W];
        end else begin : g_cmp
            assign dyad_o = (off_i < OFF_W'(DYAD_LIMIT));
        end
    endgenerate

    assign idx_o = {ctx_i, off_i[DYAD_IDX_W-1:0]};
endmodule

// File: rtl/opm_cell_bank.sv
module opm_cell_bank
    import opm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CELL_IDX_W-1:0] idx_i,
    output logic                  pres_l_o,
    output logic                  pres_r_o,
    output logic [DATA_W-1:0]     val_l_o,
    output logic [DATA_W-1:0]     val_r_o,
    input  logic                  park_i,
    input  side_e                 park_side_i,
    input  logic [DATA_W-1:0]     park_data_i,
    input  logic                  free_i
);
    typedef struct packed {
        logic [CELLS-1:0] pl;
        logic [CELLS-1:0] pr;
    } pres_t;

    pres_t pres_d, pres_q;
    logic [DATA_W-1:0] val_l_q [CELLS];
    logic [DATA_W-1:0] val_r_q [CELLS];

    assign pres_l_o = pres_q.pl[idx_i];
    assign pres_r_o = pres_q.pr[idx_i];
    assign val_l_o  = val_l_q[idx_i];
    assign val_r_o  = val_r_q[idx_i];

    always_comb begin
        pres_d = pres_q;
        if (free_i) begin
            pres_d.pl[idx_i] = 1'b0;
            pres_d.pr[idx_i] = 1'b0;
        end else if (park_i) begin
            if (park_side_i == SIDE_L) pres_d.pl[idx_i] = 1'b1;
            else                       pres_d.pr[idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pres_q <= '0;
        else        pres_q <= pres_d;
    end

    // value storage carries no reset; presence bits qualify it
    always_ff @(posedge clk) begin
        if (park_i && !free_i) begin
            if (park_side_i == SIDE_L) val_l_q[idx_i] <= park_data_i;
            else                       val_r_q[idx_i] <= park_data_i;
        end
    end

    // a side is only ever parked into an empty slot
    assert_park_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        park_i && park_side_i == SIDE_L |-> !pres_l_o);
    assert_park_empty_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
        park_i && park_side_i == SIDE_R |-> !pres_r_o);
    // freeing leaves both sides empty on the next cycle
    assert_free_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        free_i |=> !pres_q.pl[$past(idx_i)] && !pres_q.pr[$past(idx_i)]);
    // a cell is freed only when the opposite side was parked
    assert_free_needs_partner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        free_i |-> (pres_l_o ^ pres_r_o));
endmodule

// File: rtl/operand_pair_unit.sv
module operand_pair_unit
    import opm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid_i,
    output logic              tok_ready_o,
    input  logic [3:0]        tok_ctx_i,
    input  logic [6:0]        tok_off_i,
    input  logic              tok_port_i,
    input  logic [15:0]       tok_data_i,
    output logic              fire_valid_o,
    input  logic              fire_ready_i,
    output logic [3:0]        fire_ctx_o,
    output logic [6:0]        fire_off_o,
    output logic [15:0]       fire_lval_o,
    output logic [15:0]       fire_rval_o,
    output logic              fire_mono_o,
    output logic              collide_o
);
    typedef struct packed {
        fire_t pkt;
        logic  fvalid;
        logic  collide;
    } state_t;

    state_t st_d, st_q;

    logic                  accept;
    logic                  is_dyad;
    logic [CELL_IDX_W-1:0] cell_idx;
    side_e                 side;
    logic                  own_pres, other_pres;
    logic                  c_pl, c_pr;
    logic [DATA_W-1:0]     c_vl, c_vr;
    logic                  bank_park, bank_free;

    assign side        = side_e'(tok_port_i);
    assign tok_ready_o = fire_ready_i;
    assign accept      = tok_valid_i && fire_ready_i;

    opm_decode u_decode (
        .ctx_i  (tok_ctx_i),
        .off_i  (tok_off_i),
        .dyad_o (is_dyad),
        .idx_o  (cell_idx)
    );

    opm_cell_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_i       (cell_idx),
        .pres_l_o    (c_pl),
        .pres_r_o    (c_pr),
        .val_l_o     (c_vl),
        .val_r_o     (c_vr),
        .park_i      (bank_park),
        .park_side_i (side),
        .park_data_i (tok_data_i),
        .free_i      (bank_free)
    );

    assign own_pres   = (side == SIDE_L) ? c_pl : c_pr;
    assign other_pres = (side == SIDE_L) ? c_pr : c_pl;

    always_comb begin
        st_d      = st_q;
        bank_park = 1'b0;
        bank_free = 1'b0;
        if (fire_ready_i) st_d.fvalid = 1'b0;
        if (accept) begin
            if (!is_dyad) begin
                st_d.fvalid   = 1'b1;
                st_d.pkt.ctx  = tok_ctx_i;
                st_d.pkt.off  = tok_off_i;
                st_d.pkt.lval = tok_data_i;
                st_d.pkt.rval = '0;
                st_d.pkt.mono = 1'b1;
            end else if (own_pres) begin
                st_d.collide = 1'b1;
            end else if (other_pres) begin
                bank_free     = 1'b1;
                st_d.fvalid   = 1'b1;
                st_d.pkt.ctx  = tok_ctx_i;
                st_d.pkt.off  = tok_off_i;
                st_d.pkt.lval = (side == SIDE_L) ? tok_data_i : c_vl;
                st_d.pkt.rval = (side == SIDE_R) ? tok_data_i : c_vr;
                st_d.pkt.mono = 1'b0;
            end else begin
                bank_park = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_valid_o = st_q.fvalid;
    assign fire_ctx_o   = st_q.pkt.ctx;
    assign fire_off_o   = st_q.pkt.off;
    assign fire_lval_o  = st_q.pkt.lval;
    assign fire_rval_o  = st_q.pkt.rval;
    assign fire_mono_o  = st_q.pkt.mono;
    assign collide_o    = st_q.collide;

    assert_hold_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_valid_o && !fire_ready_i |=> fire_valid_o && $stable(st_q.pkt));
    assert_stall_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_valid_o && !fire_ready_i |=> !fire_valid_o);
    assert_collide_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        collide_o |=> collide_o);
    assert_mono_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !is_dyad |=> fire_valid_o && fire_mono_o && fire_rval_o == '0);
    assert_mono_no_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !is_dyad |-> !bank_park && !bank_free);
    assert_park_no_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_park |=> !fire_valid_o);
endmodule

// File: tb/operand_pair_unit_bench.sv
module operand_pair_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic        tok_ready;
    logic [3:0]  tok_ctx = '0;
    logic [6:0]  tok_off = '0;
    logic        tok_port = 1'b0;
    logic [15:0] tok_data = '0;
    logic        fire_valid;
    logic        fire_ready = 1'b0;
    logic [3:0]  fire_ctx;
    logic [6:0]  fire_off;
    logic [15:0] fire_lval, fire_rval;
    logic        fire_mono;
    logic        collide;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of cells and output
    bit          m_pl [512];
    bit          m_pr [512];
    logic [15:0] m_vl [512];
    logic [15:0] m_vr [512];
    bit          e_valid = 0;
    bit          e_col   = 0;
    logic [43:0] e_pkt   = '0;

    always #5 clk = ~clk;

    operand_pair_unit u_operand_pair_unit (
        .clk(clk), .rst_n(rst_n),
        .tok_valid_i(tok_valid), .tok_ready_o(tok_ready),
        .tok_ctx_i(tok_ctx), .tok_off_i(tok_off), .tok_port_i(tok_port), .tok_data_i(tok_data),
        .fire_valid_o(fire_valid), .fire_ready_i(fire_ready),
        .fire_ctx_o(fire_ctx), .fire_off_o(fire_off),
        .fire_lval_o(fire_lval), .fire_rval_o(fire_rval), .fire_mono_o(fire_mono),
        .collide_o(collide)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [43:0] pkt(logic [3:0] c, logic [6:0] o, logic [15:0] l, logic [15:0] r, bit m);
        return {c, o, l, r, m};
    endfunction

    // one clock: drive away from the edge, update model at the edge, compare after it
    task automatic step(input bit v, input logic [3:0] c, input logic [6:0] o, input bit p,
                        input logic [15:0] d, input bit fr, input string tag);
        bit acc, fire;
        int idx;
        bit own, oth;
        tok_valid = v; tok_ctx = c; tok_off = o; tok_port = p; tok_data = d; fire_ready = fr;
        #1;
        chk(tok_ready == fr, "R9 ready", tok_ready, fr);
        @(posedge clk);
        acc = v && fr;
        fire = 0;
        if (acc) begin
            if (o >= 7'd32) begin
                fire = 1;
                e_pkt = pkt(c, o, d, 16'h0, 1'b1);
            end else begin
                idx = {c, o[4:0]};
                own = p ? m_pr[idx] : m_pl[idx];
                oth = p ? m_pl[idx] : m_pr[idx];
                if (own) e_col = 1;
                else if (oth) begin
                    fire = 1;
                    e_pkt = pkt(c, o, p ? m_vl[idx] : d, p ? d : m_vr[idx], 1'b0);
                    m_pl[idx] = 0; m_pr[idx] = 0;
                end else if (p) begin
                    m_pr[idx] = 1; m_vr[idx] = d;
                end else begin
                    m_pl[idx] = 1; m_vl[idx] = d;
                end
            end
        end
        if (fr) e_valid = fire;
        #1;
        chk(fire_valid == e_valid, tag, fire_valid, e_valid);
        if (e_valid)
            chk({fire_ctx, fire_off, fire_lval, fire_rval, fire_mono} == e_pkt, tag,
                {fire_ctx, fire_off, fire_lval, fire_rval, fire_mono}, e_pkt);
        chk(collide == e_col, {tag, "/R8 flag"}, collide, e_col);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 512; i++) begin m_pl[i] = 0; m_pr[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk(fire_valid == 1'b0, "R1 valid", fire_valid, 0);
        chk(collide == 1'b0, "R1 collide", collide, 0);

        // R1/R4: first arrival parks
        step(1, 4'd3, 7'd5, 0, 16'hAAAA, 1, "R4");
        // R10: long wait, then partner pairs
        for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 0, 1, "R10 idle");
        step(1, 4'd3, 7'd5, 1, 16'h5555, 1, "R10");
        // R6: cell freed and reusable
        step(1, 4'd3, 7'd5, 1, 16'h1111, 1, "R6");
        step(1, 4'd3, 7'd5, 0, 16'h2222, 1, "R6");
        // R2: bypass
        step(1, 4'd2, 7'd64, 0, 16'hBEEF, 1, "R2");
        step(1, 4'd2, 7'd127, 1, 16'hCAFE, 1, "R2");
        step(1, 4'd2, 7'd32, 0, 16'h0032, 1, "R2");
        // R3: aliasing single-input offsets leave the cell alone
        step(1, 4'd1, 7'd5, 0, 16'h1234, 1, "R3");
        step(1, 4'd1, 7'd37, 1, 16'h9999, 1, "R3");
        step(1, 4'd1, 7'd37, 0, 16'h8888, 1, "R3");
        step(1, 4'd1, 7'd5, 1, 16'h4321, 1, "R3");
        // R7: context separation
        step(1, 4'd0, 7'd31, 0, 16'h000A, 1, "R7");
        step(1, 4'd15, 7'd31, 1, 16'h000B, 1, "R7");
        step(1, 4'd0, 7'd31, 1, 16'h000C, 1, "R7");
        step(1, 4'd15, 7'd31, 0, 16'h000D, 1, "R7");
        // R8: collision drops, keeps parked value
        step(1, 4'd6, 7'd0, 0, 16'h0F0F, 1, "R8");
        step(1, 4'd6, 7'd0, 0, 16'hF0F0, 1, "R8");
        step(1, 4'd6, 7'd0, 1, 16'h7777, 1, "R8");
        // R9: stall holds packet, no acceptance
        step(1, 4'd4, 7'd40, 0, 16'h4040, 1, "R9");
        for (int i = 0; i < 4; i++) step(1, 4'd4, 7'd41, 0, 16'h4141, 0, "R9");
        step(0, 0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 0, 0, "R9");

        // random stream mixed over few offsets
        for (int i = 0; i < 4000; i++) begin
            logic [6:0] o;
            case ($urandom % 6)
                0: o = 7'd0;
                1: o = 7'd5;
                2: o = 7'd31;
                3: o = 7'd37;
                4: o = 7'd100;
                default: o = 7'd5;
            endcase
            step(($urandom % 4) != 0, 4'($urandom % 3), o, 1'($urandom),
                 16'($urandom), ($urandom % 4) != 0, "R5");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule